// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used page mappings, so that a processor address can be translated to a physical one without reading the page table. The address space is 32 bits wide and pages are 4 KB. The low 12 bits of an address are the offset within the page and are never translated. The upper 20 bits are the virtual page number, and each one maps to a 20-bit physical page number. Each slot stores a valid bit, the virtual page number as its tag, the physical page number and three permission bits. The lookup page number is compared with every slot at once.

The lookup side is combinational. It takes an address and an access kind, and in the same cycle it reports a hit flag, the physical address and a permission fault flag. A miss is only reported: the page-table walk happens outside this block, and the result comes back later through the install port. The install port is a valid/ready stream. An entry is taken at a rising clock edge when `ins_valid` and `ins_ready` are both high. `ins_ready` drops only during a flush cycle. A producer that sees `ins_ready` low must hold its entry and offer it again. Raising `flush` empties the buffer at the next edge.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every slot is empty, so every lookup misses (`lk_hit`=0, `lk_paddr`=0, `lk_fault`=0).
- R2: The lookup page number is `lk_vaddr[31:12]`. When it equals the tag of a valid slot, `lk_hit` is 1 in the same cycle and `lk_paddr` is that slot's physical page number followed by `lk_vaddr[11:0]`. On a miss, `lk_hit`, `lk_paddr` and `lk_fault` are all 0.
- R3: The permission field uses bit 0 for read, bit 1 for write and bit 2 for execute. `lk_kind` is 0 for read, 1 for write, 2 for execute and 3 for reserved. `lk_fault` is 1 exactly when there is a hit and the requested kind is not permitted; a reserved kind always faults on a hit. A faulting hit still reports `lk_hit` and `lk_paddr`.
- R4: An install accepted at a clock edge is visible to lookups from the next cycle on. The contents do not change in any cycle without an accepted install or a flush.
- R5: An install whose page number matches a valid slot overwrites that slot in place. The number of occupied slots does not change.
- R6: An install with no matching slot goes into the lowest-numbered empty slot, if there is one. The replacement pointer does not change.
- R7: An install with no matching slot into a full buffer replaces the slot named by the replacement pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0. The pointer is 0 after reset, and a flush does not change it.
- R8: A flush clears every valid bit at the next edge. `ins_ready` is 0 during a flush cycle, so an install offered in that cycle is not taken. Lookups in the flush cycle still see the old contents.
- R9: No page number ever matches more than one valid slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | A valid slot matches the page number |
| lk_paddr | output | 32 | Translated address, 0 on a miss |
| lk_fault | output | 1 | Hit, but the access kind is not permitted |
| ins_valid | input | 1 | An entry is offered for install |
| ins_ready | output | 1 | The install port can accept the entry |
| ins_vpn | input | 20 | Virtual page number of the offered entry |
| ins_ppn | input | 20 | Physical page number of the offered entry |
| ins_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Invalidate all slots |

## Verification
The hardest case to reach is a replacement while the pointer sits in the middle of its range, mixed with in-place overwrites and flushes. The pointer can only be observed through which old mapping disappears. A directed sequence fills the buffer, forces two evictions in a row, overwrites one slot, and then flushes while an install is offered. After that, a long random phase draws page numbers from a pool only slightly larger than the buffer, so it keeps swinging between full and partly empty. A behavioural model predicts every lookup in every cycle, so a wrong victim shows up as soon as the evicted page is probed.

// File: rtl/tlb_xlat_pkg.sv
package tlb_xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int PN_W  = VA_W - OFF_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_t;

  // bit 0 read, bit 1 write, bit 2 execute
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef struct packed {
    logic            vld;
    logic [PN_W-1:0] vpn;
    logic [PN_W-1:0] ppn;
    perm_t           perm;
  } ent_t;

  function automatic logic acc_ok(perm_t p, acc_kind_t k);
    case (k)
      ACC_READ:  acc_ok = p.r;
      ACC_WRITE: acc_ok = p.w;
      ACC_EXEC:  acc_ok = p.x;
      default:   acc_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_xlat_cam.sv
module tlb_xlat_cam
  import tlb_xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  ent_t [ENTRIES-1:0] tbl,
  input  logic [PN_W-1:0]    key,
  output logic [ENTRIES-1:0] match,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = tbl[g].vld && (tbl[g].vpn == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) idx = IDX_W'(i);
  end

  assign any = |match;
endmodule

// File: rtl/tlb_xlat_alloc.sv
module tlb_xlat_alloc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [ENTRIES-1:0] vld,
  input  logic               dup_any,
  input  logic [IDX_W-1:0]   dup_idx,
  output logic [IDX_W-1:0]   tgt
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic             evict;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  assign free_any = ~&vld;
  assign evict    = fire && !dup_any && !free_any;

  always_comb begin
    if (dup_any)       tgt = dup_idx;
    else if (free_any) tgt = free_idx;
    else               tgt = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (evict) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic [VA_W-1:0]  lk_paddr,
  output logic             lk_fault,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [PN_W-1:0]  ins_vpn,
  input  logic [PN_W-1:0]  ins_ppn,
  input  logic [2:0]       ins_perm,
  input  logic             flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ent_t [ENTRIES-1:0] tbl;
  logic [ENTRIES-1:0] vld_vec;
  logic [ENTRIES-1:0] lk_match, ins_match;
  logic [IDX_W-1:0]   lk_idx, ins_idx, tgt;
  logic               lk_any, ins_any, fire;
  ent_t               sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign vld_vec[g] = tbl[g].vld;
  end

  tlb_xlat_cam #(.ENTRIES(ENTRIES)) u_lk_cam (
    .tbl(tbl), .key(lk_vaddr[VA_W-1:OFF_W]),
    .match(lk_match), .idx(lk_idx), .any(lk_any)
  );

  tlb_xlat_cam #(.ENTRIES(ENTRIES)) u_ins_cam (
    .tbl(tbl), .key(ins_vpn),
    .match(ins_match), .idx(ins_idx), .any(ins_any)
  );

  assign ins_ready = !flush;
  assign fire      = ins_valid && ins_ready;

  tlb_xlat_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .vld(vld_vec),
    .dup_any(ins_any), .dup_idx(ins_idx), .tgt(tgt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i].vld <= 1'b0;
    end else if (fire) begin
      tbl[tgt] <= '{vld: 1'b1, vpn: ins_vpn, ppn: ins_ppn, perm: perm_t'(ins_perm)};
    end
  end

  assign sel      = tbl[lk_idx];
  assign lk_hit   = lk_any;
  assign lk_paddr = lk_any ? {sel.ppn, lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_fault = lk_any && !acc_ok(sel.perm, acc_kind_t'(lk_kind));
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [31:0]        lk_vaddr,
  input logic               lk_hit,
  input logic [31:0]        lk_paddr,
  input logic               lk_fault,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] ins_match
);
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0])); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit); // R8
  AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R9
  AST_INSTALL_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_match)); // R5
endmodule

bind tlb_xlat tlb_xlat_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_fault(lk_fault),
  .lk_match(lk_match), .ins_match(ins_match)
);

// File: tb/sim_tlb_xlat.sv
module sim_tlb_xlat;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_hit, lk_fault, ins_ready;
  logic [31:0] lk_paddr;
  logic        ins_valid = 1'b0;
  logic [19:0] ins_vpn = '0, ins_ppn = '0;
  logic [2:0]  ins_perm = '0;
  logic        flush = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit          mv[N];
  logic [19:0] mvpn[N], mppn[N];
  logic [2:0]  mperm[N];
  int          mptr = 0;

  always #2 clk = ~clk;

  tlb_xlat #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_fault(lk_fault),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_vpn(ins_vpn),
    .ins_ppn(ins_ppn), .ins_perm(ins_perm), .flush(flush)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic step(input logic [31:0] va, input logic [1:0] kind, input bit iv,
                      input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] perm,
                      input bit fl, input string tag);
    int k;
    logic ok;
    @(negedge clk);
    lk_vaddr = va; lk_kind = kind; ins_valid = iv; ins_vpn = vpn;
    ins_ppn = ppn; ins_perm = perm; flush = fl;
    #1;
    k = find(va[31:12]);
    if (k >= 0) begin
      ok = (kind == 2'd0) ? mperm[k][0] : (kind == 2'd1) ? mperm[k][1] :
           (kind == 2'd2) ? mperm[k][2] : 1'b0;
      check(tag, "hit", {31'd0, lk_hit}, 32'd1);
      check(tag, "paddr", lk_paddr, {mppn[k], va[11:0]});
      check(tag, "fault", {31'd0, lk_fault}, {31'd0, !ok});
    end else begin
      check(tag, "hit", {31'd0, lk_hit}, 32'd0);
      check(tag, "paddr", lk_paddr, 32'd0);
      check(tag, "fault", {31'd0, lk_fault}, 32'd0);
    end
    check("R8", "ready", {31'd0, ins_ready}, {31'd0, !fl});
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) mv[i] = 1'b0;
    end else if (iv) begin
      k = find(vpn);
      if (k < 0) for (int i = N - 1; i >= 0; i--) if (!mv[i]) k = i;
      if (k < 0) begin k = mptr; mptr = (mptr + 1) % N; end
      mv[k] = 1'b1; mvpn[k] = vpn; mppn[k] = ppn; mperm[k] = perm;
    end
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] kind, input string tag);
    step({vpn, off}, kind, 1'b0, '0, '0, '0, 1'b0, tag);
  endtask

  task automatic put(input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] perm, input string tag);
    step(32'h0, 2'd0, 1'b1, vpn, ppn, perm, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look(20'h00000, 12'h000, 2'd0, "R1");
    look(20'h12345, 12'h678, 2'd0, "R1");

    // R2/R3/R4: read-only mapping, all access kinds
    put(20'h12345, 20'hABCDE, 3'b001, "R4");
    look(20'h12345, 12'h678, 2'd0, "R2");
    look(20'h12345, 12'hFFF, 2'd1, "R3");
    look(20'h12345, 12'h001, 2'd2, "R3");
    look(20'h12345, 12'h000, 2'd3, "R3");
    put(20'h00777, 20'h00001, 3'b110, "R6");
    look(20'h00777, 12'h123, 2'd1, "R3");
    look(20'h00777, 12'h123, 2'd2, "R3");
    look(20'h00777, 12'h123, 2'd0, "R3");

    // R6: fill the remaining slots
    for (int i = 0; i < N - 2; i++) put(20'h00100 + 20'(i), 20'h50000 + 20'(i), 3'b111, "R6");
    for (int i = 0; i < N - 2; i++) look(20'h00100 + 20'(i), 12'hABC, 2'd2, "R6");

    // R7: two evictions from a full buffer
    put(20'h00200, 20'h60000, 3'b011, "R7");
    look(20'h12345, 12'h000, 2'd0, "R7");
    put(20'h00201, 20'h60001, 3'b011, "R7");
    look(20'h00777, 12'h000, 2'd0, "R7");
    look(20'h00200, 12'h010, 2'd1, "R7");

    // R5: overwrite in place, nothing else lost
    put(20'h00103, 20'h7FFFF, 3'b100, "R5");
    look(20'h00103, 12'h444, 2'd2, "R5");
    for (int i = 0; i < N - 2; i++) look(20'h00100 + 20'(i), 12'h0, 2'd0, "R5");
    look(20'h00201, 12'h0, 2'd0, "R5");

    // R8: flush with an install offered; old contents visible in that cycle
    step({20'h00200, 12'h5}, 2'd0, 1'b1, 20'h00999, 20'h11111, 3'b111, 1'b1, "R8");
    look(20'h00200, 12'h5, 2'd0, "R8");
    look(20'h00999, 12'h5, 2'd0, "R8");

    // R7: pointer kept across flush, refill then evict
    for (int i = 0; i < N; i++) put(20'h00300 + 20'(i), 20'h22200 + 20'(i), 3'b101, "R6");
    put(20'h00400, 20'h33333, 3'b111, "R7");
    for (int i = 0; i < N; i++) look(20'h00300 + 20'(i), 12'h0, 2'd0, "R7");

    // R9/R4: random traffic over a small page pool
    for (int t = 0; t < 4000; t++) begin
      logic [31:0] r;
      r = $urandom;
      step({20'h00A00 + 20'(r[3:0] % 12), r[15:4]}, r[17:16], r[18] | r[19],
           20'h00A00 + 20'(r[23:20] % 12), {12'h0, r[31:24]}, r[26:24],
           (r[31:27] == 5'd0), "R9");
    end

    finish_run();
  end
endmodule